// File: doc/BRIEF.md
# Nibble-Serial Register Access Decoder

This block sits behind a byte-wide host link and turns a stream of command bytes into accesses on a small internal 8-bit register file. The upper four bits of every byte select an operation and the lower four bits carry a payload nibble. A register address is built from two address commands, and a data byte is built from two data commands. The command that supplies the high data nibble is also the write strobe.

A read command places one byte, the content of the addressed register, into a single-entry response slot. That slot drives a valid/ready output stream. A read variant advances the address after the read, so that the host can drain a multi-byte field, such as a pair of 24-bit positions, with a run of identical commands.

The block holds a read-only identification register and a read/write scratch register, which the host uses to test the link. It also holds a parameterised bank of general read/write registers.

Top module: `nibreg_decoder`

Register layout: address 0x00 is the identification register, address 0x01 is the scratch register, and addresses 0x02 up to 0x02+GP_COUNT-1 are the general registers (0x02..0x09 at the default GP_COUNT of 8). Every other address is unmapped.

## Requirements
- R1: A synchronous active-low reset clears the address to 0x00, the pending low data nibble to 0x0, the response slot to empty, and the scratch and general registers to 0x00. After reset `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: Opcode 0x0 loads the payload into address bits 3:0 and keeps bits 7:4. Opcode 0x1 loads the payload into address bits 7:4 and keeps bits 3:0.
- R3: Opcode 0x2 stores the payload as the pending low data nibble. Opcode 0x3 writes the byte {payload, pending nibble} to the currently addressed register.
- R4: Several low/high data pairs after one address each write the same register, and the address does not move. The last pair wins.
- R5: Opcode 0x4 or 0x5 puts exactly one byte, the value the addressed register held when the command was accepted, into the response slot. `rsp_valid` is 1 from the cycle after acceptance until a cycle in which `rsp_ready` is 1.
- R6: Opcode 0x5 advances the address by one after the read, wrapping from 0xFF to 0x00. Opcode 0x4 leaves the address unchanged. Six consecutive 0x5 reads return six successive registers in ascending address order.
- R7: The identification register at address 0x00 always reads 0xA6, and writes to it have no effect.
- R8: The scratch register at address 0x01 returns the last byte written to it. Writing 0x55 and reading gives 0x55, and then writing 0xAA and reading gives 0xAA.
- R9: Opcodes 0x6 to 0xF change neither the address, the pending nibble, any register, nor the response stream.
- R10: The pending low data nibble survives address commands and is kept until a later opcode 0x2 replaces it.
- R11: While the response slot is full, `cmd_ready` is 0 and no command is accepted. While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_data` is held.
- R12: Reads of unmapped addresses return 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command byte is offered |
| cmd_ready | output | 1 | The block accepts the offered byte this cycle |
| cmd_data | input | 8 | Command byte: opcode in bits 7:4, payload in bits 3:0 |
| rsp_valid | output | 1 | The response slot holds a read byte |
| rsp_ready | input | 1 | The consumer takes the response byte this cycle |
| rsp_data | output | 8 | Read byte |

## Verification
The bench goes after the corner cases where a decoder slips quietly:
- A low data nibble left pending across address commands. A design that cleared it on addressing would write a zero low nibble.
- A lone high-address nibble. A design that zeroed the other half of the address would read the wrong register.
- A read-with-increment at address 0xFF. A design that did not wrap the address would lose the identification register.
- Opcodes 0x6 to 0xF, some of whose payloads look like data. A design with loose decode would corrupt the scratch register or emit stray responses.
- A held response with a command waiting behind it. A design without the stall would overwrite the held byte, or drop the waiting command.
- A reset between the two data nibbles, which must leave no stale nibble behind.

// File: rtl/nibreg_pkg.sv
// Package: shared opcode encoding and register layout for the nibble
// command decoder. Assumes an 8-bit address built from two nibbles.
package nibreg_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int NIB_W  = 4;

    // Command opcodes carried in bits 7:4 of each byte
    typedef enum logic [NIB_W-1:0] {
        OP_ADR_LO   = 4'h0,
        OP_ADR_HI   = 4'h1,
        OP_DAT_LO   = 4'h2,
        OP_DAT_HI_W = 4'h3,
        OP_RD       = 4'h4,
        OP_RD_STEP  = 4'h5
    } nib_op_e;

    localparam logic [NIB_W-1:0]  OP_LAST_VALID = 4'h5;
    localparam logic [ADDR_W-1:0] ADDR_IDENT    = 8'h00;
    localparam logic [ADDR_W-1:0] ADDR_SCRATCH  = 8'h01;
    localparam logic [ADDR_W-1:0] ADDR_GP_BASE  = 8'h02;
    localparam logic [DATA_W-1:0] IDENT_VALUE   = 8'hA6;

endpackage

// File: rtl/nibreg_cmd_decode.sv
// Module: splits each accepted command byte into opcode and payload,
// keeps the assembled address and the pending low data nibble, and
// raises one-cycle write and read strobes.
// Assumes cmd_fire is high only when the block can take the byte.
module nibreg_cmd_decode
    import nibreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_fire,
    input  logic [7:0]        cmd_byte,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_en
);

    logic [NIB_W-1:0] op;
    logic [NIB_W-1:0] nib;
    logic [NIB_W-1:0] lo_q;
    logic             rd_step;

    assign op  = cmd_byte[7:4];
    assign nib = cmd_byte[3:0];

    // Decode the strobes of the accepted command
    always_comb begin
        wr_en   = cmd_fire && (op == OP_DAT_HI_W);
        rd_en   = cmd_fire && ((op == OP_RD) || (op == OP_RD_STEP));
        rd_step = cmd_fire && (op == OP_RD_STEP);
        wr_data = {nib, lo_q};
    end

    // Assemble the address nibbles and advance after a stepping read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (cmd_fire) begin
            if (op == OP_ADR_LO) begin
                addr_q[3:0] <= nib;
            end else if (op == OP_ADR_HI) begin
                addr_q[7:4] <= nib;
            end else if (rd_step) begin
                addr_q <= addr_q + 8'd1;
            end
        end
    end

    // Hold the low data nibble until a later low-data command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (cmd_fire && (op == OP_DAT_LO)) begin
            lo_q <= nib;
        end
    end

    // R2
    adr_lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && op == OP_ADR_LO) |=>
            (addr_q[7:4] == $past(addr_q[7:4])) && (addr_q[3:0] == $past(nib)));

    // R2
    adr_hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && op == OP_ADR_HI) |=>
            (addr_q[3:0] == $past(addr_q[3:0])) && (addr_q[7:4] == $past(nib)));

    // R6
    read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_step |=> addr_q == 8'($past(addr_q) + 8'd1));

    // R9
    foreign_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && op > OP_LAST_VALID) |=> ($stable(addr_q) && $stable(lo_q)));

    // R10
    lo_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && (op == OP_ADR_LO || op == OP_ADR_HI)) |=> $stable(lo_q));

endmodule

// File: rtl/nibreg_file.sv
// Module: the register file. It holds a fixed identification value, a
// scratch register and GP_COUNT general registers, each 8 bits wide.
// Assumes one write per cycle, and gives a combinational read at any address.
module nibreg_file
    import nibreg_pkg::*;
#(
    parameter int GP_COUNT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int GP_END = int'(ADDR_GP_BASE) + GP_COUNT;

    logic [DATA_W-1:0] scratch_q;
    logic [DATA_W-1:0] gp_q [GP_COUNT];

    // Scratch register: written only at its own address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch_q <= '0;
        end else if (wr_en && wr_addr == ADDR_SCRATCH) begin
            scratch_q <= wr_data;
        end
    end

    // One general register for each slot
    for (genvar g = 0; g < GP_COUNT; g++) begin : g_gp
        localparam logic [ADDR_W-1:0] SLOT = 8'(int'(ADDR_GP_BASE) + g);
        logic [DATA_W-1:0] q;

        // Capture writes that address this slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && wr_addr == SLOT) begin
                q <= wr_data;
            end
        end

        assign gp_q[g] = q;
    end

    // Read mux: the identification value, scratch, general, or zero
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_IDENT) begin
            rd_data = IDENT_VALUE;
        end else if (rd_addr == ADDR_SCRATCH) begin
            rd_data = scratch_q;
        end else if (int'(rd_addr) < GP_END) begin
            for (int i = 0; i < GP_COUNT; i++) begin
                if (rd_addr == 8'(int'(ADDR_GP_BASE) + i)) begin
                    rd_data = gp_q[i];
                end
            end
        end
    end

    // R3
    scratch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_SCRATCH) |=> scratch_q == $past(wr_data));

    // R8
    scratch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADDR_SCRATCH) |=> $stable(scratch_q));

endmodule

// File: rtl/nibreg_rsp_slot.sv
// Module: a single-entry response holder with valid/ready output.
// Assumes load is only raised while the slot is free.
module nibreg_rsp_slot
    import nibreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              rsp_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              slot_free
);

    // Fill on a read and drain on the consumer handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else if (load) begin
            rsp_valid <= 1'b1;
            rsp_data  <= load_data;
        end else if (rsp_valid && rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

    assign slot_free = !rsp_valid;

    // R5
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (rsp_valid && rsp_data == $past(load_data)));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    // R11
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !load);

endmodule

// File: rtl/nibreg_decoder.sv
// Module: the top of the nibble command decoder. It joins the command
// decoder, the register file and the response slot.
// Assumes one command byte per cycle at most, and that the host observes cmd_ready.
module nibreg_decoder
    import nibreg_pkg::*;
#(
    parameter int GP_COUNT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [7:0] cmd_data,
    output logic       rsp_valid,
    input  logic       rsp_ready,
    output logic [7:0] rsp_data
);

    logic              cmd_fire;
    logic              slot_free;
    logic [ADDR_W-1:0] cur_addr;
    logic              wr_en;
    logic              rd_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    // Take a command only when a read could land in the slot
    assign cmd_ready = slot_free;
    assign cmd_fire  = cmd_valid && cmd_ready;

    nibreg_cmd_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_fire (cmd_fire),
        .cmd_byte (cmd_data),
        .addr_q   (cur_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en)
    );

    nibreg_file #(.GP_COUNT(GP_COUNT)) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (cur_addr),
        .wr_data (wr_data),
        .rd_addr (cur_addr),
        .rd_data (rd_data)
    );

    nibreg_rsp_slot u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rd_en),
        .load_data (rd_data),
        .rsp_ready (rsp_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .slot_free (slot_free)
    );

    // R7
    ident_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cur_addr == ADDR_IDENT) |=> rsp_data == IDENT_VALUE);

    // R11
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready && cmd_valid) |=> $stable(cur_addr));

endmodule

// File: tb/sim_nibreg_decoder.sv
// Bench: a behavioural reference model that is compared on every clock,
// plus directed checks built from the requirements.
module sim_nibreg_decoder;

    localparam int GP = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic       cmd_ready;
    logic [7:0] cmd_data;
    logic       rsp_valid;
    logic       rsp_ready;
    logic [7:0] rsp_data;

    always #4 clk = ~clk;

    nibreg_decoder #(.GP_COUNT(GP)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_data  (cmd_data),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_data  (rsp_data)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Reference model state
    bit         m_valid;
    logic [7:0] m_data;
    logic [7:0] m_addr;
    logic [3:0] m_lo;
    logic [7:0] m_mem [256];

    function automatic bit m_writable(input logic [7:0] a);
        return (a == 8'h01) || (a >= 8'h02 && int'(a) < 2 + GP);
    endfunction

    function automatic logic [7:0] m_rd(input logic [7:0] a);
        if (a == 8'h00) return 8'hA6;
        if (m_writable(a)) return m_mem[a];
        return 8'h00;
    endfunction

    // Model step on each clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 0; m_data = 0; m_addr = 0; m_lo = 0;
            for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
        end else begin
            bit nv;
            nv = m_valid && !rsp_ready;
            if (cmd_valid && !m_valid) begin
                case (cmd_data[7:4])
                    4'h0: m_addr[3:0] = cmd_data[3:0];
                    4'h1: m_addr[7:4] = cmd_data[3:0];
                    4'h2: m_lo = cmd_data[3:0];
                    4'h3: if (m_writable(m_addr)) m_mem[m_addr] = {cmd_data[3:0], m_lo};
                    4'h4, 4'h5: begin
                        m_data = m_rd(m_addr);
                        nv = 1;
                        if (cmd_data[7:4] == 4'h5) m_addr = m_addr + 8'd1;
                    end
                    default: ;
                endcase
            end
            m_valid = nv;
        end
    end

    // Per-cycle comparison against the model (R5, R11)
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            chk(cmd_ready == !m_valid, "R11 cmd_ready", int'(cmd_ready), int'(!m_valid));
            chk(rsp_valid == m_valid, "R5 rsp_valid", int'(rsp_valid), int'(m_valid));
            if (m_valid) chk(rsp_data == m_data, "R5 rsp_data", rsp_data, m_data);
        end
    end

    task automatic send(input logic [7:0] b);
        cmd_data  = b;
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic set_addr(input logic [7:0] a);
        send({4'h0, a[3:0]});
        send({4'h1, a[7:4]});
    endtask

    task automatic write_byte(input logic [7:0] d);
        send({4'h2, d[3:0]});
        send({4'h3, d[7:4]});
    endtask

    task automatic read_exp(input logic [7:0] exp, input bit step, input string req);
        send(step ? 8'h50 : 8'h40);
        chk(rsp_valid === 1'b1 && rsp_data === exp, req, rsp_data, exp);
    endtask

    // Watchdog
    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL R1 watchdog actual=0x0 expected=0x1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_data = 8'h00; rsp_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state after reset
        chk(cmd_ready === 1'b1 && rsp_valid === 1'b0, "R1 idle after reset",
            int'({cmd_ready, rsp_valid}), 2);
        read_exp(8'hA6, 0, "R1 R7 address zero after reset");

        // R8: link test on the scratch register
        set_addr(8'h01);
        write_byte(8'h55); read_exp(8'h55, 0, "R8 scratch 0x55");
        write_byte(8'hAA); read_exp(8'hAA, 0, "R8 scratch 0xAA");

        // R7: a write to the identification register is dropped
        set_addr(8'h00); write_byte(8'h12);
        read_exp(8'hA6, 0, "R7 ident read-only");

        // R3: a write to a general register
        set_addr(8'h05); write_byte(8'h3C);
        set_addr(8'h02); write_byte(8'h71);
        set_addr(8'h05); read_exp(8'h3C, 0, "R3 general write");

        // R2: a lone high nibble keeps the low nibble
        set_addr(8'h09); write_byte(8'h9E);
        set_addr(8'h39);
        send(8'h10);
        read_exp(8'h9E, 0, "R2 high nibble only");

        // R4: several pairs after one address
        set_addr(8'h03);
        write_byte(8'h11); write_byte(8'h22); write_byte(8'hD3);
        read_exp(8'hD3, 0, "R4 repeated pairs");

        // R10: the pending nibble survives address commands
        set_addr(8'h04);
        send(8'h2C);
        send(8'h06); send(8'h10);
        send(8'h33);
        read_exp(8'h3C, 0, "R10 pending nibble kept");

        // R9: foreign opcodes do nothing
        set_addr(8'h01); write_byte(8'h5A);
        send(8'h6F); chk(rsp_valid === 1'b0, "R9 no response 0x6F", int'(rsp_valid), 0);
        send(8'hFF); chk(rsp_valid === 1'b0, "R9 no response 0xFF", int'(rsp_valid), 0);
        send(8'h9A); send(8'hE1); send(8'hD7);
        read_exp(8'h5A, 0, "R9 scratch and address kept");
        send(8'h36);
        read_exp(8'h6A, 0, "R9 pending nibble kept");

        // R12: an unmapped address
        set_addr(8'h40); write_byte(8'hFF);
        read_exp(8'h00, 0, "R12 unmapped reads zero");

        // R6: six stepping reads, then plain reads
        for (int i = 2; i <= 8; i++) begin
            set_addr(8'(i)); write_byte(8'(i * 16 + i));
        end
        set_addr(8'h02);
        for (int i = 2; i <= 7; i++) read_exp(8'(i * 16 + i), 1, "R6 stepping read");
        read_exp(8'h88, 0, "R6 plain read after steps");
        read_exp(8'h88, 0, "R6 plain read does not move");

        // R6: the address wraps
        set_addr(8'hFF);
        read_exp(8'h00, 1, "R6 read at 0xFF");
        read_exp(8'hA6, 0, "R6 wrap to 0x00");

        // R11: a held response stalls a waiting command
        set_addr(8'h01); write_byte(8'h77);
        rsp_ready = 1'b0;
        send(8'h40);
        chk(rsp_valid === 1'b1 && cmd_ready === 1'b0, "R11 stall begins",
            int'({rsp_valid, cmd_ready}), 2);
        cmd_data = 8'h00; cmd_valid = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!cmd_ready && rsp_valid && rsp_data == 8'h77, "R11 held", rsp_data, 8'h77);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        read_exp(8'hA6, 0, "R11 waiting command applied");

        // R1: a reset between the data nibbles leaves no stale nibble
        send(8'h2F);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        set_addr(8'h01);
        send(8'h33);
        read_exp(8'h30, 0, "R1 nibble cleared by reset");

        repeat (2) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule